// File: doc/BRIEF.md
# Repeater List SHA-1 Message Packer

This block prepares the message that a SHA-1 engine hashes when a content-protection transmitter checks the identity list reported by a downstream repeater. It takes a count of downstream receivers, their 5-byte identifiers as a byte stream, and the repeater's two topology status bytes. It then produces a stream of 32-bit words. Each word carries a tag that tells the hash engine how many of its bytes are message text. The hash engine fills the remaining bytes from its own 8-byte session secret.

The 40-bit identifiers are packed big-endian across 32-bit words, so 0 to 3 bytes carry over to the end of the list. The carry count selects one of four tail sequences, which place the status bytes and the secret filler slots. After the tail, the block pads with zero words until one slot is left in the 64-byte block. It then emits the message length in bits and, one cycle later, pulses a "complete hash" command. A count of zero is refused: the block emits no words and pulses a reject flag instead.

Top module: `rl_sha_msg_packer`

## Requirements
- R1: After reset, `busy_o`, `word_valid_o`, `id_ready_o`, `hash_done_o` and `reject_o` are all low.
- R2: A start with a device count of zero pulses `reject_o` for exactly one cycle. It emits no word and requests no identifier byte.
- R3: The tag field `word_tag_o` gives the number of text bytes in a word: 0, 1, 2, 3 or 4 (0, 8, 16, 24 or 32 text bits). Identifier bytes are packed four per word, first byte in bits 31:24, each word tagged 4. This includes words that start on a 64-byte boundary.
- R4: With no carried bytes, the tail is three words: `{16'h0, status0, status1}` with tag 2, a zero word with tag 0, and a zero word with tag 2.
- R5: With one carried byte b, the tail is three words: `{8'h0, b, status0, status1}` with tag 3, a zero word with tag 0, and a zero word with tag 1.
- R6: With two carried bytes b0 and b1, the tail is three words: `{b0, b1, status0, status1}` with tag 4, followed by two zero words with tag 0.
- R7: With three carried bytes b0, b1 and b2, the tail is four words: `{b0, b1, b2, status0}` with tag 4, `{24'h0, status1}` with tag 1, a zero word with tag 0, and a zero word with tag 3.
- R8: After the tail, zero words with tag 4 follow until the next word would be the 16th word of a 16-word block.
- R9: The last word of the message is (count*5+10)*8 with tag 4, so the total word count is a multiple of 16.
- R10: `hash_done_o` is high for exactly one cycle, in the cycle after the length word is accepted. The block is idle in the following cycle.
- R11: While `word_valid_o` is high and `word_ready_i` is low, the word and its tag stay unchanged. No word is lost or repeated under stalls on either stream.
- R12: A start request while the block is busy has no effect on the message in progress and causes no reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a message (sampled while idle) |
| dev_count_i | input | CNT_W | Number of downstream identifiers |
| stat_a_i | input | 8 | First topology status byte |
| stat_b_i | input | 8 | Second topology status byte |
| id_valid_i | input | 1 | Identifier byte valid |
| id_byte_i | input | 8 | Identifier byte, in list order |
| id_ready_o | output | 1 | Identifier byte accepted when high with valid |
| word_valid_o | output | 1 | Output word valid |
| word_data_o | output | 32 | Output word |
| word_tag_o | output | 3 | Text byte count of the output word |
| word_ready_i | input | 1 | Hash engine accepts the word |
| hash_done_o | output | 1 | Complete-hash command pulse |
| reject_o | output | 1 | Zero-count start refused |
| busy_o | output | 1 | Message in progress |

## Verification
The hardest case to reach is the moment the last identifier byte lands: the carried-byte count then picks the tail. That count may fall together with a full word waiting on a stalled hash engine. The bench sweeps consecutive device counts, so every carry value from 0 to 3 appears several times. It runs each count once with free-running handshakes and once with interleaved valid and ready gaps. A large list crosses several 64-byte block boundaries inside the identifier section. A start with a zero count is injected mid-message to show that it is ignored while busy.

// File: rtl/rl_pack_pkg.sv
package rl_pack_pkg;

  localparam int WORD_W        = 32;
  localparam int ID_BYTES      = 5;
  localparam int TRAILER_BYTES = 10;
  localparam int BLOCK_WORDS   = 16;
  localparam int SLOT_W        = $clog2(BLOCK_WORDS);

  // number of text bytes in a word
  typedef enum logic [2:0] {
    TAG_NONE = 3'd0,
    TAG_B1   = 3'd1,
    TAG_B2   = 3'd2,
    TAG_B3   = 3'd3,
    TAG_FULL = 3'd4
  } tag_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LIST = 3'd1,
    ST_TAIL = 3'd2,
    ST_PAD  = 3'd3,
    ST_LEN  = 3'd4,
    ST_DONE = 3'd5,
    ST_REJ  = 3'd6
  } phase_e;

endpackage

// File: rtl/rl_reset_sync.sv
module rl_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rl_byte_gather.sv
module rl_byte_gather
  import rl_pack_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              accept_i,
  input  logic [7:0]        byte_i,
  input  logic              take_i,
  output logic [WORD_W-1:0] acc_o,
  output logic [2:0]        fill_o,
  output logic              left_zero_o
);

  localparam int LEFT_W = CNT_W + 3;

  logic [WORD_W-1:0] acc_q, acc_d;
  logic [2:0]        fill_q, fill_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              acc_en, ctl_en;

  assign acc_en = accept_i;
  assign ctl_en = load_i | accept_i | take_i;

  always_comb begin
    acc_d  = {acc_q[WORD_W-9:0], byte_i};
    fill_d = fill_q;
    left_d = left_q;
    if (load_i) begin
      fill_d = 3'd0;
      left_d = LEFT_W'(count_i) * LEFT_W'(ID_BYTES);
    end else begin
      if (take_i)   fill_d = 3'd0;
      if (accept_i) begin
        fill_d = fill_q + 3'd1;
        left_d = left_q - LEFT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 3'd0;
      left_q <= '0;
    end else if (ctl_en) begin
      fill_q <= fill_d;
      left_q <= left_d;
    end
  end

  assign acc_o       = acc_q;
  assign fill_o      = fill_q;
  assign left_zero_o = (left_q == '0);

endmodule

// File: rtl/rl_tail_seq.sv
module rl_tail_seq
  import rl_pack_pkg::*;
(
  input  logic [1:0]        lo_i,
  input  logic [1:0]        step_i,
  input  logic [23:0]       carry_i,
  input  logic [7:0]        sa_i,
  input  logic [7:0]        sb_i,
  output logic [WORD_W-1:0] word_o,
  output tag_e              tag_o,
  output logic              last_o
);

  always_comb begin
    word_o = '0;
    tag_o  = TAG_NONE;
    last_o = 1'b0;
    unique case (lo_i)
      2'd0: begin
        unique case (step_i)
          2'd0:    begin word_o = {16'h0, sa_i, sb_i}; tag_o = TAG_B2; end
          2'd1:    tag_o = TAG_NONE;
          default: begin tag_o = TAG_B2; last_o = 1'b1; end
        endcase
      end
      2'd1: begin
        unique case (step_i)
          2'd0:    begin word_o = {8'h0, carry_i[7:0], sa_i, sb_i}; tag_o = TAG_B3; end
          2'd1:    tag_o = TAG_NONE;
          default: begin tag_o = TAG_B1; last_o = 1'b1; end
        endcase
      end
      2'd2: begin
        unique case (step_i)
          2'd0:    begin word_o = {carry_i[15:0], sa_i, sb_i}; tag_o = TAG_FULL; end
          2'd1:    tag_o = TAG_NONE;
          default: begin tag_o = TAG_NONE; last_o = 1'b1; end
        endcase
      end
      default: begin
        unique case (step_i)
          2'd0:    begin word_o = {carry_i, sa_i}; tag_o = TAG_FULL; end
          2'd1:    begin word_o = {24'h0, sb_i}; tag_o = TAG_B1; end
          2'd2:    tag_o = TAG_NONE;
          default: begin tag_o = TAG_B3; last_o = 1'b1; end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/rl_pad_tracker.sv
module rl_pad_tracker
  import rl_pack_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              advance_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              pre_last_o,
  output logic [WORD_W-1:0] len_bits_o
);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              slot_en;

  assign slot_en = clear_i | advance_i;

  always_comb begin
    slot_d = slot_q + SLOT_W'(1);
    if (clear_i) slot_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= '0;
    else if (slot_en) slot_q <= slot_d;
  end

  assign pre_last_o = (slot_q == SLOT_W'(BLOCK_WORDS - 2));
  assign len_bits_o = WORD_W'(count_i) * WORD_W'(ID_BYTES * 8) + WORD_W'(TRAILER_BYTES * 8);

endmodule

// File: rtl/rl_sha_msg_packer.sv
module rl_sha_msg_packer
  import rl_pack_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] dev_count_i,
  input  logic [7:0]       stat_a_i,
  input  logic [7:0]       stat_b_i,
  input  logic             id_valid_i,
  input  logic [7:0]       id_byte_i,
  output logic             id_ready_o,
  output logic             word_valid_o,
  output logic [31:0]      word_data_o,
  output logic [2:0]       word_tag_o,
  input  logic             word_ready_i,
  output logic             hash_done_o,
  output logic             reject_o,
  output logic             busy_o
);

  logic              rst_q_n;
  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        sa_q, sb_q;
  logic [1:0]        lo_q, lo_d, step_q, step_d;
  logic              start_acc, load, accept, fire, take;
  logic [WORD_W-1:0] acc;
  logic [2:0]        fill;
  logic              left_zero, word_full;
  logic [WORD_W-1:0] tail_word, len_bits;
  tag_e              tail_tag, w_tag;
  logic              tail_last, pre_last, w_valid;
  logic [WORD_W-1:0] w_data;

  rl_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign start_acc = (state_q == ST_IDLE) && start_i;
  assign load      = start_acc && (dev_count_i != '0);
  assign word_full = (fill == 3'd4);
  assign id_ready_o = (state_q == ST_LIST) && !word_full && !left_zero;
  assign accept    = id_valid_i && id_ready_o;

  assign w_valid = ((state_q == ST_LIST) && word_full) ||
                   (state_q == ST_TAIL) || (state_q == ST_PAD) || (state_q == ST_LEN);
  assign fire    = w_valid && word_ready_i;
  assign take    = fire && (state_q == ST_LIST);

  rl_byte_gather #(.CNT_W(CNT_W)) u_gather (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .load_i      (load),
    .count_i     (dev_count_i),
    .accept_i    (accept),
    .byte_i      (id_byte_i),
    .take_i      (take),
    .acc_o       (acc),
    .fill_o      (fill),
    .left_zero_o (left_zero)
  );

  rl_tail_seq u_tail (
    .lo_i    (lo_q),
    .step_i  (step_q),
    .carry_i (acc[23:0]),
    .sa_i    (sa_q),
    .sb_i    (sb_q),
    .word_o  (tail_word),
    .tag_o   (tail_tag),
    .last_o  (tail_last)
  );

  rl_pad_tracker #(.CNT_W(CNT_W)) u_pad (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .clear_i    (load),
    .advance_i  (fire),
    .count_i    (cnt_q),
    .pre_last_o (pre_last),
    .len_bits_o (len_bits)
  );

  always_comb begin
    state_d = state_q;
    lo_d    = lo_q;
    step_d  = step_q;
    w_data  = '0;
    w_tag   = TAG_FULL;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = (dev_count_i == '0) ? ST_REJ : ST_LIST;
      end
      ST_LIST: begin
        w_data = acc;
        if (left_zero && (!word_full || fire)) begin
          state_d = ST_TAIL;
          lo_d    = fill[1:0];
          step_d  = 2'd0;
        end
      end
      ST_TAIL: begin
        w_data = tail_word;
        w_tag  = tail_tag;
        if (fire) begin
          step_d = step_q + 2'd1;
          if (tail_last) state_d = pre_last ? ST_LEN : ST_PAD;
        end
      end
      ST_PAD: begin
        if (fire && pre_last) state_d = ST_LEN;
      end
      ST_LEN: begin
        w_data = len_bits;
        if (fire) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      lo_q    <= 2'd0;
      step_q  <= 2'd0;
    end else begin
      state_q <= state_d;
      lo_q    <= lo_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt_q <= '0;
      sa_q  <= 8'h0;
      sb_q  <= 8'h0;
    end else if (start_acc) begin
      cnt_q <= dev_count_i;
      sa_q  <= stat_a_i;
      sb_q  <= stat_b_i;
    end
  end

  assign word_valid_o = w_valid;
  assign word_data_o  = w_data;
  assign word_tag_o   = w_tag;
  assign hash_done_o  = (state_q == ST_DONE);
  assign reject_o     = (state_q == ST_REJ);
  assign busy_o       = (state_q != ST_IDLE);

endmodule

// File: rtl/rl_sha_msg_packer_chk.sv
module rl_sha_msg_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        id_ready_o,
  input logic        word_valid_o,
  input logic [31:0] word_data_o,
  input logic [2:0]  word_tag_o,
  input logic        word_ready_i,
  input logic        hash_done_o,
  input logic        reject_o,
  input logic        busy_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !word_valid_o && !id_ready_o && !hash_done_o); // R1

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> !word_valid_o && !id_ready_o); // R2

  AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> word_tag_o <= 3'd4); // R3

  AST_INPUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    id_ready_o |-> !word_valid_o); // R3

  AST_DONE_AFTER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    hash_done_o |-> $past(word_valid_o && word_ready_i && word_tag_o == 3'd4)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hash_done_o |=> !hash_done_o && !busy_o); // R10

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_data_o) && $stable(word_tag_o)); // R11

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hash_done_o, reject_o})); // R12

endmodule

bind rl_sha_msg_packer rl_sha_msg_packer_chk u_chk (.*);

// File: tb/rl_sha_msg_packer_tb.sv
`timescale 1ns/1ps
module rl_sha_msg_packer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [6:0]  dev_count_i;
  logic [7:0]  stat_a_i, stat_b_i;
  logic        id_valid_i;
  logic [7:0]  id_byte_i;
  logic        id_ready_o;
  logic        word_valid_o;
  logic [31:0] word_data_o;
  logic [2:0]  word_tag_o;
  logic        word_ready_i;
  logic        hash_done_o, reject_o, busy_o;

  int checks = 0;
  int errors = 0;

  logic [34:0] exp_w [0:511];
  string       exp_r [0:511];
  int          exp_n;

  always #2 clk = ~clk;

  rl_sha_msg_packer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_count_i(dev_count_i),
    .stat_a_i(stat_a_i), .stat_b_i(stat_b_i), .id_valid_i(id_valid_i),
    .id_byte_i(id_byte_i), .id_ready_o(id_ready_o), .word_valid_o(word_valid_o),
    .word_data_o(word_data_o), .word_tag_o(word_tag_o), .word_ready_i(word_ready_i),
    .hash_done_o(hash_done_o), .reject_o(reject_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int n, input int k);
    return 8'((k * 29 + n * 13 + 7) & 255);
  endfunction

  task automatic push(input logic [31:0] w, input logic [2:0] t, input string r);
    exp_w[exp_n] = {t, w};
    exp_r[exp_n] = r;
    exp_n++;
  endtask

  task automatic build(input int n, input logic [7:0] sa, input logic [7:0] sb);
    int nb, nf, lo;
    nb = 5 * n; nf = nb / 4; lo = nb % 4; exp_n = 0;
    for (int i = 0; i < nf; i++)
      push({bval(n, 4*i), bval(n, 4*i+1), bval(n, 4*i+2), bval(n, 4*i+3)}, 3'd4, "R3");
    case (lo)
      0: begin push({16'h0, sa, sb}, 3'd2, "R4"); push(32'h0, 3'd0, "R4"); push(32'h0, 3'd2, "R4"); end
      1: begin push({8'h0, bval(n, nb-1), sa, sb}, 3'd3, "R5"); push(32'h0, 3'd0, "R5"); push(32'h0, 3'd1, "R5"); end
      2: begin push({bval(n, nb-2), bval(n, nb-1), sa, sb}, 3'd4, "R6"); push(32'h0, 3'd0, "R6"); push(32'h0, 3'd0, "R6"); end
      default: begin
        push({bval(n, nb-3), bval(n, nb-2), bval(n, nb-1), sa}, 3'd4, "R7");
        push({24'h0, sb}, 3'd1, "R7"); push(32'h0, 3'd0, "R7"); push(32'h0, 3'd3, "R7");
      end
    endcase
    while (exp_n % 16 != 15) push(32'h0, 3'd4, "R8");
    push(32'((n * 5 + 10) * 8), 3'd4, "R9");
  endtask

  task automatic run_case(input int n, input int mode);
    logic [7:0] sa, sb;
    int bi, wi, rej, last_fire;
    bit got_done, hold_pend;
    logic [34:0] held;
    sa = 8'(n); sb = 8'(8'h11 + n);
    build(n, sa, sb);
    @(negedge clk);
    dev_count_i = 7'(n); stat_a_i = sa; stat_b_i = sb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (n == 0) begin
      #1;
      chk(reject_o === 1'b1, "R2", {39'h0, reject_o}, 40'h1);
      chk(!word_valid_o && !id_ready_o, "R2", {38'h0, word_valid_o, id_ready_o}, 40'h0);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); #1;
        chk(!reject_o && !word_valid_o && !busy_o, "R2",
            {37'h0, reject_o, word_valid_o, busy_o}, 40'h0);
      end
      return;
    end
    bi = 0; wi = 0; rej = 0; last_fire = -10; got_done = 0; hold_pend = 0; held = '0;
    for (int cyc = 0; cyc < 20000 && !got_done; cyc++) begin
      if (cyc == 6) begin start_i = 1'b1; dev_count_i = 7'd0; end
      else begin start_i = 1'b0; dev_count_i = 7'(n); end
      id_valid_i   = (bi < 5 * n) && (mode == 0 || ((cyc * 3 + n) % 5) != 0);
      id_byte_i    = bval(n, bi);
      word_ready_i = (mode == 0) || (((cyc * 5 + n) % 4) < 2);
      #1;
      if (reject_o) rej++;
      if (hold_pend)
        chk(word_valid_o && {word_tag_o, word_data_o} == held, "R11",
            {word_valid_o, 1'b0, word_tag_o, word_data_o}, {5'h10, held});
      hold_pend = word_valid_o && !word_ready_i;
      held      = {word_tag_o, word_data_o};
      if (hash_done_o) begin
        got_done = 1;
        chk(wi == exp_n && last_fire == cyc - 1, "R10", 40'(wi), 40'(exp_n));
      end
      if (word_valid_o && word_ready_i) begin
        if (wi < exp_n)
          chk({word_tag_o, word_data_o} == exp_w[wi], exp_r[wi],
              {5'h0, word_tag_o, word_data_o}, {5'h0, exp_w[wi]});
        else
          chk(1'b0, "R9", {5'h0, word_tag_o, word_data_o}, 40'h0);
        wi++;
        last_fire = cyc;
      end
      if (id_valid_i && id_ready_o) bi++;
      @(negedge clk);
    end
    start_i = 1'b0; id_valid_i = 1'b0; word_ready_i = 1'b0; dev_count_i = 7'(n);
    chk(got_done, "R10", {39'h0, got_done}, 40'h1);
    chk(wi == exp_n && bi == 5 * n, "R11", 40'(wi), 40'(exp_n));
    chk(rej == 0, "R12", 40'(rej), 40'h0);
    #1;
    chk(!busy_o && !hash_done_o, "R10", {38'h0, busy_o, hash_done_o}, 40'h0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; dev_count_i = '0; stat_a_i = '0; stat_b_i = '0;
    id_valid_i = 1'b0; id_byte_i = '0; word_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk({busy_o, word_valid_o, id_ready_o, hash_done_o, reject_o} == 5'b0, "R1",
        {35'h0, busy_o, word_valid_o, id_ready_o, hash_done_o, reject_o}, 40'h0);
    for (int n = 0; n <= 24; n++)
      for (int m = 0; m < 2; m++) run_case(n, m);
    run_case(64, 0);
    run_case(127, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule